// File: doc/BRIEF.md
# Accumulator Register-Add Execution Unit

This block runs the one-byte "add source to accumulator" instruction group of a small 8-bit accumulator machine. It fetches an opcode over a simple memory bus, decodes the low three bits as a source selector, and adds that source to the accumulator. The source is one of the general registers, the accumulator itself, or a memory byte addressed by the H (high byte) and L (low byte) register pair. The sum is written back to the accumulator, five status flags are updated, and the program counter moves past the one-byte instruction.

Each bus cycle lasts three clocks. In the first clock the block drives the address and pulses `ale_o`. In the next two clocks it holds `rd_o` high, and it captures `data_i` on the clock edge that ends the second of those clocks. A register-source add takes one fetch cycle plus a decode clock, 4 T-states in total. A memory-source add adds a 3-T-state read cycle, 7 T-states in total.

A host stops the unit by holding `run_i` low. The unit finishes the instruction in progress and then rests in the idle state. While it is idle, the host can preload registers through the load port, and it can read any register through the readback port at any time.

Top module: `acc_add_unit`

States and transitions:
- `ST_IDLE` goes to `ST_FT1` when `run_i` is high. Otherwise it stays in `ST_IDLE`, and this is the only state that accepts loads.
- The fetch cycle runs `ST_FT1` → `ST_FT2` → `ST_FT3` → `ST_FT4`. `ST_FT4` is the decode clock.
- From `ST_FT4`:
  - A memory-source add goes to `ST_MT1`.
  - Anything else goes to `ST_FT1` if `run_i` is high, or to `ST_IDLE` if it is low.
- The read cycle runs `ST_MT1` → `ST_MT2` → `ST_MT3`.
- From `ST_MT3`, the unit goes to `ST_FT1` if `run_i` is high, or to `ST_IDLE` if it is low.

## Requirements
- R1: After reset, all registers, the flags and the program counter read zero, `ale_o` and `rd_o` are low, and the unit is idle.
- R2: Opcodes 0x80–0x87 add the selected source to the accumulator and replace the accumulator with the 8-bit sum. The source is chosen by opcode bits [2:0]: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory, 7=accumulator. The source register keeps its value; for example, A=0x02 plus E=0x03 leaves A=0x05 and E=0x03.
- R3: Source code 6 reads the memory byte at address {H, L}, with H as the high byte.
- R4: The program counter increases by one for every instruction, including unrecognised ones.
- R5: A register-source add takes 4 T-states, so the next fetch's `ale_o` pulse comes 4 clocks after the current one.
- R6: A memory-source add takes 7 T-states. Its read cycle's `ale_o` pulse comes 4 clocks after the fetch pulse, and the next fetch pulse comes 7 clocks after the fetch pulse.
- R7: The flags are `flags_o` = {S, Z, AC, P, CY}, where bit 0 is CY (carry out of bit 7), bit 1 is P (even parity of the result), bit 2 is AC (carry out of bit 3), bit 3 is Z (result is zero) and bit 4 is S (result bit 7).
- R8: Every bus cycle has `ale_o` high for exactly its first clock, `rd_o` high for the next two clocks, and `addr_o` valid through all three. Data is captured at the edge that ends the second `rd_o` clock.
- R9: Any opcode outside 0x80–0x87 takes 4 T-states and changes neither the accumulator, the other registers nor the flags.
- R10: Loads are accepted only in `ST_IDLE`. A load with selector 6 is ignored, and readback of selector 6 returns 0x00. With `run_i` low, the unit finishes the current instruction and then idles.
- R11: Opcode 0x87 leaves twice the old accumulator value, modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Keep fetching instructions while high |
| ld_en_i | input | 1 | Register preload strobe (honoured when idle) |
| ld_sel_i | input | 3 | Preload register selector (source encoding) |
| ld_data_i | input | 8 | Preload value |
| rb_sel_i | input | 3 | Readback register selector |
| rb_data_o | output | 8 | Readback value |
| data_i | input | 8 | Memory read data |
| addr_o | output | 16 | Memory address |
| ale_o | output | 1 | Address strobe, first clock of a bus cycle |
| rd_o | output | 1 | Read strobe, second and third clocks |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 5 | Status flags {S, Z, AC, P, CY} |
| pc_o | output | 16 | Program counter |

## Verification
The assertions check several properties on every clock:
- Each address strobe is followed by a read strobe exactly two clocks long.
- The program counter steps after every decode clock.
- The read cycle is entered only for the memory-source opcode.
- Unloaded registers hold their value.
- After each accumulator write, the zero, sign and parity flags agree with the new accumulator.
- Unrecognised opcodes leave the accumulator and flags untouched.
- Self-addition doubles the accumulator.

Other behaviours are shown only by the bench's scenarios, where the reference model compares the bus and architectural state every clock:
- The exact sums.
- The carry and auxiliary-carry values.
- The source decoding.
- The H:L addressing.
- The 4-versus-7 T-state spacing.
- The idle and load rules.

// File: rtl/acc_add_pkg.sv
package acc_add_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_FT1  = 3'd1,
        ST_FT2  = 3'd2,
        ST_FT3  = 3'd3,
        ST_FT4  = 3'd4,
        ST_MT1  = 3'd5,
        ST_MT2  = 3'd6,
        ST_MT3  = 3'd7
    } tstate_e;

    localparam int OPC_W  = 8;
    localparam int SEL_W  = 3;
    localparam int NREG   = 1 << SEL_W;
    localparam int FLAG_W = 5;

    localparam logic [OPC_W-SEL_W-1:0] ADD_GROUP = 5'b10000;

    localparam logic [SEL_W-1:0] SEL_H   = 3'd4;
    localparam logic [SEL_W-1:0] SEL_L   = 3'd5;
    localparam logic [SEL_W-1:0] SEL_MEM = 3'd6;
    localparam logic [SEL_W-1:0] SEL_ACC = 3'd7;

    localparam int FLG_CY  = 0;
    localparam int FLG_PAR = 1;
    localparam int FLG_AUX = 2;
    localparam int FLG_ZER = 3;
    localparam int FLG_SGN = 4;

endpackage

// File: rtl/acc_add_alu.sv
module acc_add_alu
    import acc_add_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] sum_o,
    output logic [FLAG_W-1:0] flags_o
);

    localparam int HALF = DATA_W / 2;

    logic [DATA_W:0] full_sum;
    logic [HALF:0]   low_sum;

    assign full_sum = {1'b0, a_i} + {1'b0, b_i};
    assign low_sum  = {1'b0, a_i[HALF-1:0]} + {1'b0, b_i[HALF-1:0]};
    assign sum_o    = full_sum[DATA_W-1:0];

    always_comb begin
        flags_o          = '0;
        flags_o[FLG_CY]  = full_sum[DATA_W];
        flags_o[FLG_PAR] = ~^full_sum[DATA_W-1:0];
        flags_o[FLG_AUX] = low_sum[HALF];
        flags_o[FLG_ZER] = (full_sum[DATA_W-1:0] == '0);
        flags_o[FLG_SGN] = full_sum[DATA_W-1];
    end

endmodule

// File: rtl/acc_add_regfile.sv
module acc_add_regfile
    import acc_add_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_en_i,
    input  logic [SEL_W-1:0]    ld_sel_i,
    input  logic [DATA_W-1:0]   ld_data_i,
    input  logic                acc_we_i,
    input  logic [DATA_W-1:0]   acc_data_i,
    input  logic [FLAG_W-1:0]   flags_data_i,
    input  logic [SEL_W-1:0]    src_sel_i,
    output logic [DATA_W-1:0]   src_data_o,
    input  logic [SEL_W-1:0]    rb_sel_i,
    output logic [DATA_W-1:0]   rb_data_o,
    output logic [DATA_W-1:0]   acc_o,
    output logic [2*DATA_W-1:0] hl_o,
    output logic [FLAG_W-1:0]   flags_o
);

    logic [DATA_W-1:0] regs_q [NREG];
    logic [FLAG_W-1:0] flags_q;

    // Slot SEL_MEM holds no register: it stays zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
            flags_q <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (ld_en_i && (ld_sel_i == SEL_W'(i)) && (SEL_W'(i) != SEL_MEM)) begin
                    regs_q[i] <= ld_data_i;
                end
            end
            if (acc_we_i) begin
                regs_q[SEL_ACC] <= acc_data_i;
                flags_q         <= flags_data_i;
            end
        end
    end

    assign src_data_o = regs_q[src_sel_i];
    assign rb_data_o  = regs_q[rb_sel_i];
    assign acc_o      = regs_q[SEL_ACC];
    assign hl_o       = {regs_q[SEL_H], regs_q[SEL_L]};
    assign flags_o    = flags_q;

    // General registers change only through the load port.
    for (genvar g = 0; g < 6; g++) begin : g_hold
        assert_src_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !(ld_en_i && (ld_sel_i == SEL_W'(g))) |=> $stable(regs_q[g]))
            else $error("general register changed without a load");
    end

endmodule

// File: rtl/acc_add_seq.sv
module acc_add_seq
    import acc_add_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [ADDR_W-1:0] hl_i,
    output tstate_e           state_o,
    output logic [OPC_W-1:0]  ir_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ale_o,
    output logic              rd_o,
    output logic              acc_we_o,
    output logic              is_add_o,
    output logic              ld_ok_o
);

    tstate_e           state_q, state_d;
    logic [OPC_W-1:0]  ir_q;
    logic [ADDR_W-1:0] pc_q;
    logic              is_add, is_mem;

    assign is_add = (ir_q[OPC_W-1:SEL_W] == ADD_GROUP);
    assign is_mem = is_add && (ir_q[SEL_W-1:0] == SEL_MEM);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Instruction and program counter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q <= '0;
            pc_q <= '0;
        end else begin
            if (state_q == ST_FT3) begin
                ir_q <= data_i[OPC_W-1:0];
            end
            if (state_q == ST_FT4) begin
                pc_q <= pc_q + ADDR_W'(1);
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = run_i ? ST_FT1 : ST_IDLE;
            ST_FT1:  state_d = ST_FT2;
            ST_FT2:  state_d = ST_FT3;
            ST_FT3:  state_d = ST_FT4;
            ST_FT4:  begin
                if (is_mem) begin
                    state_d = ST_MT1;
                end else begin
                    state_d = run_i ? ST_FT1 : ST_IDLE;
                end
            end
            ST_MT1:  state_d = ST_MT2;
            ST_MT2:  state_d = ST_MT3;
            ST_MT3:  state_d = run_i ? ST_FT1 : ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ale_o    = 1'b0;
        rd_o     = 1'b0;
        acc_we_o = 1'b0;
        addr_o   = pc_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_FT1:  ale_o = 1'b1;
            ST_FT2,
            ST_FT3:  rd_o  = 1'b1;
            ST_FT4:  acc_we_o = is_add && !is_mem;
            ST_MT1:  begin
                addr_o = hl_i;
                ale_o  = 1'b1;
            end
            ST_MT2:  begin
                addr_o = hl_i;
                rd_o   = 1'b1;
            end
            ST_MT3:  begin
                addr_o   = hl_i;
                rd_o     = 1'b1;
                acc_we_o = 1'b1;
            end
        endcase
    end

    assign state_o  = state_q;
    assign ir_o     = ir_q;
    assign pc_o     = pc_q;
    assign is_add_o = is_add;
    assign ld_ok_o  = (state_q == ST_IDLE);

    assert_ale_then_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> rd_o) else $error("read strobe did not follow address strobe");

    assert_rd_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_o) |=> rd_o) else $error("read strobe shorter than two clocks");

    assert_rd_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_o && $past(rd_o)) |=> !rd_o) else $error("read strobe longer than two clocks");

    assert_pc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FT4) |=> (pc_q == $past(pc_q) + ADDR_W'(1)))
        else $error("program counter did not advance by one");

    assert_mem_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MT1) |-> (ir_q == {ADD_GROUP, SEL_MEM}))
        else $error("read cycle entered for a non-memory opcode");

endmodule

// File: rtl/acc_add_unit.sv
module acc_add_unit
    import acc_add_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                ld_en_i,
    input  logic [2:0]          ld_sel_i,
    input  logic [DATA_W-1:0]   ld_data_i,
    input  logic [2:0]          rb_sel_i,
    output logic [DATA_W-1:0]   rb_data_o,
    input  logic [DATA_W-1:0]   data_i,
    output logic [2*DATA_W-1:0] addr_o,
    output logic                ale_o,
    output logic                rd_o,
    output logic [DATA_W-1:0]   acc_o,
    output logic [4:0]          flags_o,
    output logic [2*DATA_W-1:0] pc_o
);

    localparam int ADDR_W = 2 * DATA_W;

    tstate_e           state;
    logic [OPC_W-1:0]  ir;
    logic              acc_we, is_add, ld_ok;
    logic [ADDR_W-1:0] hl;
    logic [DATA_W-1:0] src_data, operand, sum;
    logic [FLAG_W-1:0] new_flags;

    acc_add_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_i),
        .data_i   (data_i),
        .hl_i     (hl),
        .state_o  (state),
        .ir_o     (ir),
        .pc_o     (pc_o),
        .addr_o   (addr_o),
        .ale_o    (ale_o),
        .rd_o     (rd_o),
        .acc_we_o (acc_we),
        .is_add_o (is_add),
        .ld_ok_o  (ld_ok)
    );

    acc_add_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .ld_en_i      (ld_en_i && ld_ok),
        .ld_sel_i     (ld_sel_i),
        .ld_data_i    (ld_data_i),
        .acc_we_i     (acc_we),
        .acc_data_i   (sum),
        .flags_data_i (new_flags),
        .src_sel_i    (ir[SEL_W-1:0]),
        .src_data_o   (src_data),
        .rb_sel_i     (rb_sel_i),
        .rb_data_o    (rb_data_o),
        .acc_o        (acc_o),
        .hl_o         (hl),
        .flags_o      (flags_o)
    );

    // Operand mux: memory byte in the last read clock, else register file.
    assign operand = (state == ST_MT3) ? data_i : src_data;

    acc_add_alu #(.DATA_W(DATA_W)) u_alu (
        .a_i     (acc_o),
        .b_i     (operand),
        .sum_o   (sum),
        .flags_o (new_flags)
    );

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |=> (flags_o[FLG_ZER] == (acc_o == '0)))
        else $error("zero flag disagrees with accumulator");

    assert_parity_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |=> (flags_o[FLG_PAR] == ~^acc_o))
        else $error("parity flag disagrees with accumulator");

    assert_sign_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |=> (flags_o[FLG_SGN] == acc_o[DATA_W-1]))
        else $error("sign flag disagrees with accumulator");

    assert_nop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_FT4) && !is_add) |=> ($stable(acc_o) && $stable(flags_o)))
        else $error("unrecognised opcode changed accumulator or flags");

    assert_double_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && (state == ST_FT4) && (ir[SEL_W-1:0] == SEL_ACC))
            |=> (acc_o == {$past(acc_o[DATA_W-2:0]), 1'b0}))
        else $error("self-add did not double the accumulator");

endmodule

// File: tb/acc_add_unit_tb_top.sv
module acc_add_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run;
    logic        ld_en;
    logic [2:0]  ld_sel;
    logic [7:0]  ld_data;
    logic [2:0]  rb_sel;
    logic [7:0]  rb_data;
    logic [7:0]  data_in;
    logic [15:0] addr;
    logic        ale, rd;
    logic [7:0]  acc;
    logic [4:0]  flags;
    logic [15:0] pc;

    always #10 clk = ~clk;

    acc_add_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .ld_en_i   (ld_en),
        .ld_sel_i  (ld_sel),
        .ld_data_i (ld_data),
        .rb_sel_i  (rb_sel),
        .rb_data_o (rb_data),
        .data_i    (data_in),
        .addr_o    (addr),
        .ale_o     (ale),
        .rd_o      (rd),
        .acc_o     (acc),
        .flags_o   (flags),
        .pc_o      (pc)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int aleq[$];

    logic [7:0] mem [int];

    // reference model state
    logic [7:0]  m_reg [8];
    logic [4:0]  m_flg;
    logic [15:0] m_pc;
    logic [7:0]  m_ir;
    int          ph;

    function automatic logic [7:0] memrd(input int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic m_add(input logic [7:0] b);
        logic [8:0] s;
        logic [4:0] lo;
        s  = {1'b0, m_reg[7]} + {1'b0, b};
        lo = {1'b0, m_reg[7][3:0]} + {1'b0, b[3:0]};
        m_flg = {s[7], (s[7:0] == 8'h00), lo[4], ~^s[7:0], s[8]};
        m_reg[7] = s[7:0];
    endtask

    task automatic step();
        case (ph)
            0: begin
                if (ld_en && ld_sel != 3'd6) m_reg[ld_sel] = ld_data;
                if (run) ph = 1;
            end
            1: ph = 2;
            2: ph = 3;
            3: begin m_ir = memrd(int'(m_pc)); ph = 4; end
            4: begin
                m_pc = m_pc + 16'd1;
                if (m_ir[7:3] == 5'b10000 && m_ir[2:0] == 3'd6) ph = 5;
                else begin
                    if (m_ir[7:3] == 5'b10000) m_add(m_reg[m_ir[2:0]]);
                    ph = run ? 1 : 0;
                end
            end
            5: ph = 6;
            6: ph = 7;
            default: begin
                m_add(memrd(int'({m_reg[4], m_reg[5]})));
                ph = run ? 1 : 0;
            end
        endcase
    endtask

    task automatic compare();
        bit e_ale, e_rd;
        logic [15:0] e_addr;
        e_ale  = (ph == 1 || ph == 5);
        e_rd   = (ph == 2 || ph == 3 || ph == 6 || ph == 7);
        e_addr = (ph >= 5) ? {m_reg[4], m_reg[5]} : m_pc;
        chk(ale == e_ale, "R8", "ale", 32'(ale), 32'(e_ale));
        chk(rd == e_rd, "R8", "rd", 32'(rd), 32'(e_rd));
        if (e_ale || e_rd)
            chk(addr == e_addr, (ph >= 5) ? "R3" : "R8", "addr", 32'(addr), 32'(e_addr));
        chk(acc == m_reg[7], "R2", "acc", 32'(acc), 32'(m_reg[7]));
        chk(flags == m_flg, "R7", "flags", 32'(flags), 32'(m_flg));
        chk(pc == m_pc, "R4", "pc", 32'(pc), 32'(m_pc));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cyc++;
        step();
        compare();
        if (ale) aleq.push_back(cyc);
        data_in = rd ? memrd(int'(addr)) : 8'h00;
    endtask

    task automatic drain();
        run = 1'b0;
        for (int n = 0; n < 40 && ph != 0; n++) tick();
    endtask

    task automatic run_one();
        run = 1'b1;
        tick();
        run = 1'b0;
        drain();
    endtask

    task automatic exec(input logic [7:0] opc);
        mem[int'(m_pc)] = opc;
        run_one();
    endtask

    task automatic load(input logic [2:0] s, input logic [7:0] v);
        ld_en = 1'b1; ld_sel = s; ld_data = v;
        tick();
        ld_en = 1'b0;
    endtask

    task automatic rb(input logic [2:0] s, output logic [7:0] v);
        rb_sel = s;
        #1;
        v = rb_data;
    endtask

    task automatic chk_regs(input string req);
        logic [7:0] v;
        for (int s = 0; s < 8; s++) begin
            rb(3'(s), v);
            if (s == 6) chk(v == 8'h00, req, "readback slot 6", 32'(v), 32'h0);
            else        chk(v == m_reg[s], req, "readback", 32'(v), 32'(m_reg[s]));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst_n = 1'b0; run = 1'b0; ld_en = 1'b0; ld_sel = '0; ld_data = '0;
        rb_sel = '0; data_in = '0;
        for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
        m_flg = '0; m_pc = '0; m_ir = '0; ph = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(acc == 8'h00, "R1", "acc", 32'(acc), 32'h0);
        chk(flags == 5'h00, "R1", "flags", 32'(flags), 32'h0);
        chk(pc == 16'h0, "R1", "pc", 32'(pc), 32'h0);
        chk(!ale && !rd, "R1", "strobes", 32'({ale, rd}), 32'h0);
        chk_regs("R1");

        // R2: A=02, E=03, ADD E
        load(3'd7, 8'h02);
        load(3'd3, 8'h03);
        exec(8'h83);
        rb(3'd7, v); chk(v == 8'h05, "R2", "A after add E", 32'(v), 32'h05);
        rb(3'd3, v); chk(v == 8'h03, "R2", "E kept", 32'(v), 32'h03);
        chk(pc == 16'd1, "R4", "pc after one", 32'(pc), 32'd1);

        // R11: self-add
        exec(8'h87);
        chk(acc == 8'h0A, "R11", "double", 32'(acc), 32'h0A);

        // R3 / R6: memory source, timing
        load(3'd4, 8'h12);
        load(3'd5, 8'h34);
        mem[32'h1234] = 8'h7F;
        mem[int'(m_pc)] = 8'h86;
        mem[int'(m_pc) + 1] = 8'h80;
        aleq.delete();
        run = 1'b1;
        repeat (11) tick();
        run = 1'b0;
        drain();
        chk(aleq.size() == 3, "R6", "strobe count", 32'(aleq.size()), 32'd3);
        if (aleq.size() >= 3) begin
            chk(aleq[1] - aleq[0] == 4, "R6", "read cycle offset", 32'(aleq[1] - aleq[0]), 32'd4);
            chk(aleq[2] - aleq[0] == 7, "R6", "memory add length", 32'(aleq[2] - aleq[0]), 32'd7);
        end
        chk(acc == 8'h89, "R3", "acc after memory add", 32'(acc), 32'h89);

        // R5 / R9: register add and nop spacing
        mem[int'(m_pc)] = 8'h83;
        mem[int'(m_pc) + 1] = 8'h3C;
        mem[int'(m_pc) + 2] = 8'h81;
        aleq.delete();
        run = 1'b1;
        repeat (12) tick();
        run = 1'b0;
        drain();
        chk(aleq.size() == 3, "R5", "strobe count", 32'(aleq.size()), 32'd3);
        if (aleq.size() >= 3) begin
            chk(aleq[1] - aleq[0] == 4, "R5", "register add length", 32'(aleq[1] - aleq[0]), 32'd4);
            chk(aleq[2] - aleq[1] == 4, "R9", "nop length", 32'(aleq[2] - aleq[1]), 32'd4);
        end

        // R7 flag corners
        load(3'd7, 8'h80); load(3'd0, 8'h80);
        exec(8'h80);
        chk(flags == 5'b01011, "R7", "zero+carry", 32'(flags), 32'h0B);
        load(3'd7, 8'h0F); load(3'd1, 8'h01);
        exec(8'h81);
        chk(flags == 5'b00100, "R7", "aux carry", 32'(flags), 32'h04);
        load(3'd7, 8'h7F); load(3'd2, 8'h01);
        exec(8'h82);
        chk(flags == 5'b10100, "R7", "sign", 32'(flags), 32'h14);

        // R9 unrecognised opcodes leave state
        v = acc;
        exec(8'h3C);
        exec(8'h88);
        chk(acc == v, "R9", "acc kept", 32'(acc), 32'(v));
        chk(flags == 5'b10100, "R9", "flags kept", 32'(flags), 32'h14);
        chk_regs("R9");

        // R10 slot 6 load ignored, idle gating
        load(3'd6, 8'hAA);
        chk_regs("R10");
        repeat (5) tick();
        chk(ph == 0 && !ale, "R10", "idle with run low", 32'(ale), 32'h0);

        // random mix
        for (int it = 0; it < 25; it++) begin
            for (int k = 0; k < 3; k++) load(3'($urandom % 8), 8'($urandom));
            mem[int'({m_reg[4], m_reg[5]})] = 8'($urandom);
            for (int k = 0; k < 6; k++) begin
                int r;
                r = $urandom % 10;
                mem[int'(m_pc) + k] = (r < 8) ? (8'h80 | 8'(r)) : 8'($urandom);
            end
            run = 1'b1;
            repeat (30) tick();
            drain();
            chk_regs("R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule